// File: doc/BRIEF.md
# Interrupt Mapping Mode Autodetector

This block sits beside a PCI host bridge and watches the configuration-space writes that software issues through it. It makes a single decision: should the bridge's interrupt routing follow the legacy pass-through mapping that older, faulty guest software expects, or the correct slot-based mapping? The decision is driven by the values that software writes into the interrupt-line register (byte offset 0x3C of each function's configuration header).

The mode starts from a reset-time value and is then refined by the first interrupt-line write that can tell the two kinds of software apart. Each known faulty guest writes a characteristic value for a given slot. A characteristic value selects the legacy mapping. Any other value selects the correct mapping. After either decision is made, the mode stays fixed until the next reset, so well-behaved software can later use the register freely. Forwarding the write, serving reads and routing the interrupt lines are handled elsewhere.

Top module: `irq_mode_detect`

## Requirements
- R1: The mode is encoded as 0 = undecided (assume correct), 1 = legacy mapping, 2 = correct mapping forced. While reset is asserted, `route_mode` takes the value of `init_mode`. An `init_mode` of 3 loads 0. The value 3 never appears on `route_mode`.
- R2: While the mode is 0, an examined write of the value 27 for a slot whose slot number mod 4 is not 2 sets the mode to 1.
- R3: While the mode is 0, an examined write of the value 27 for a slot whose slot number mod 4 is 2 leaves the mode at 0, and later writes are still classified.
- R4: While the mode is 0, an examined write of the value 27 + (slot mod 4) sets the mode to 1.
- R5: While the mode is 0, an examined write of the value 91 + (slot mod 4) sets the mode to 1.
- R6: While the mode is 0, an examined write of any value not covered by R2 to R5 sets the mode to 2.
- R7: A write is examined only when `cfg_wr_en` is 1 and `cfg_addr[7:0]` equals 0x3C. Any other write leaves the mode unchanged. Only `cfg_wdata[7:0]` is compared.
- R8: When `alt_bridge` is 1, no write is examined, and the mode does not change.
- R9: Once the mode is 1 or 2, it does not change until the next reset, whatever is written.
- R10: The slot number is `cfg_addr[15:11]`, which are the upper five bits of the device/function field `cfg_addr[15:8]`. Only the slot number mod 4 affects the classification.
- R11: The new mode appears on `route_mode` right after the clock edge that samples the examined write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_bridge | input | 1 | Alternate bridge variant; disables detection |
| init_mode | input | 2 | Mode loaded at reset (3 is taken as 0) |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W (16) | Configuration address: [7:0] register offset, [15:8] device/function |
| cfg_wdata | input | 8 | Write data byte |
| route_mode | output | 2 | Sticky routing mode (0 undecided, 1 legacy, 2 correct) |

## Verification
A wrong internal state shows up on `route_mode` one cycle after the write that caused it. Because the mode is sticky, an error is never corrected by later traffic. It persists until reset, so one misclassified write stays visible on every later sample. The quietest failure is an undecided result (R3) that was in fact recorded as decided. It can only be seen when a later, distinct write fails to move the mode. For this reason, the bench follows each ambiguous write with a probing write.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;
  typedef enum logic [1:0] {
    MODE_UNSURE = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FORCED = 2'd2
  } mode_t;

  function automatic mode_t load_value(logic [1:0] raw);
    return (raw == 2'd3) ? MODE_UNSURE : mode_t'(raw);
  endfunction
endpackage

// File: rtl/irqdet_decode.sv
module irqdet_decode #(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFS = 8'h3C,
  parameter int NUM_PINS = 4,
  localparam int PIN_W   = $clog2(NUM_PINS),
  localparam int SLOT_LO = 11,
  localparam int SLOT_HI = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              line_hit,
  output logic [PIN_W-1:0]  slot_mod
);
  logic [SLOT_HI-SLOT_LO:0] slot;

  assign slot     = addr[SLOT_HI:SLOT_LO];
  assign line_hit = (addr[7:0] == 8'(LINE_OFS));

  generate
    if ((NUM_PINS & (NUM_PINS - 1)) == 0) begin : g_pow2
      assign slot_mod = slot[PIN_W-1:0];
      wire unused_slot_hi = ^slot[SLOT_HI-SLOT_LO:PIN_W];
    end else begin : g_mod
      assign slot_mod = PIN_W'(slot % 5'(NUM_PINS));
    end
    if (ADDR_W > SLOT_HI + 1) begin : g_wide
      wire unused_addr_hi = ^addr[ADDR_W-1:SLOT_HI+1];
    end
  endgenerate

  wire unused_fn_bits = ^addr[SLOT_LO-1:8];
endmodule

// File: rtl/irqdet_classify.sv
module irqdet_classify
  import irqdet_pkg::*;
#(
  parameter int NUM_PINS   = 4,
  parameter int BASE_IRQ   = 27,
  parameter int SHIFT_OFS  = 64,
  parameter int AMBIG_SLOT = 2,
  localparam int PIN_W     = $clog2(NUM_PINS)
) (
  input  logic [PIN_W-1:0] slot_mod,
  input  logic [7:0]       value,
  output mode_t            verdict
);
  function automatic mode_t judge(logic [PIN_W-1:0] s, logic [7:0] v);
    logic [7:0] s8;
    s8 = 8'(s);
    if (v == 8'(BASE_IRQ))
      return (s == PIN_W'(AMBIG_SLOT)) ? MODE_UNSURE : MODE_LEGACY;
    if (v == 8'(BASE_IRQ) + s8)
      return MODE_LEGACY;
    if (v == 8'(BASE_IRQ + SHIFT_OFS) + s8)
      return MODE_LEGACY;
    return MODE_FORCED;
  endfunction

  assign verdict = judge(slot_mod, value);
endmodule

// File: rtl/irqdet_state.sv
module irqdet_state
  import irqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] init_mode,
  input  logic       examine,
  input  mode_t      verdict,
  output mode_t      mode
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= load_value(init_mode);
    else if (examine && mode_q == MODE_UNSURE)
      mode_q <= verdict;
  end

  assign mode = mode_q;
endmodule

// File: rtl/irq_mode_detect.sv
module irq_mode_detect
  import irqdet_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_OFS   = 8'h3C,
  parameter int NUM_PINS   = 4,
  parameter int BASE_IRQ   = 27,
  parameter int SHIFT_OFS  = 64,
  parameter int AMBIG_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_bridge,
  input  logic [1:0]        init_mode,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [1:0]        route_mode
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic             line_hit;
  logic [PIN_W-1:0] slot_mod;
  logic             examine;
  mode_t            verdict;
  mode_t            mode;

  irqdet_decode #(
    .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .NUM_PINS(NUM_PINS)
  ) u_decode (
    .addr(cfg_addr), .line_hit(line_hit), .slot_mod(slot_mod)
  );

  irqdet_classify #(
    .NUM_PINS(NUM_PINS), .BASE_IRQ(BASE_IRQ),
    .SHIFT_OFS(SHIFT_OFS), .AMBIG_SLOT(AMBIG_SLOT)
  ) u_classify (
    .slot_mod(slot_mod), .value(cfg_wdata), .verdict(verdict)
  );

  assign examine = cfg_wr_en && line_hit && !alt_bridge;

  irqdet_state u_state (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
    .examine(examine), .verdict(verdict), .mode(mode)
  );

  assign route_mode = mode;
endmodule

// File: rtl/irqdet_chk.sv
module irqdet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alt_bridge,
  input logic       examine,
  input logic [1:0] verdict,
  input logic [1:0] mode
);
  // R1: the unused encoding never appears
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R9: a decided mode is held
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(mode));

  // R7: writes that are not examined do nothing
  a_r7_no_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !examine |=> $stable(mode));

  // R8: the alternate variant never moves the mode
  a_r8_alt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    alt_bridge |=> $stable(mode));

  // R2 / R4 / R5: a legacy signature is taken on the next cycle (R11)
  a_r2_legacy_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (examine && mode == 2'd0 && verdict == 2'd1) |=> mode == 2'd1);

  // R6: any other value forces the correct mapping
  a_r6_forced_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (examine && mode == 2'd0 && verdict == 2'd2) |=> mode == 2'd2);

  // R3: an ambiguous value keeps the mode undecided
  a_r3_ambiguous_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (examine && mode == 2'd0 && verdict == 2'd0) |=> mode == 2'd0);
endmodule

bind irq_mode_detect irqdet_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alt_bridge(alt_bridge),
  .examine(examine), .verdict(verdict), .mode(route_mode)
);

// File: tb/tb_irq_mode_detect.sv
module tb_irq_mode_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_bridge = 1'b0;
  logic [1:0]  init_mode = 2'd0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  route_mode;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [1:0] model;

  always #2.5 clk = ~clk;

  irq_mode_detect dut (
    .clk(clk), .rst_n(rst_n), .alt_bridge(alt_bridge), .init_mode(init_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .route_mode(route_mode)
  );

  function automatic logic [1:0] expect_verdict(logic [4:0] slot, logic [7:0] v);
    int s;
    s = int'(slot) % 4;
    if (int'(v) == 27)      return (s == 2) ? 2'd0 : 2'd1;
    if (int'(v) == 27 + s)  return 2'd1;
    if (int'(v) == 91 + s)  return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(string req, logic [1:0] exp);
    vectors++;
    if (route_mode !== exp) begin
      errors++;
      $display("FAIL %s: route_mode=%0d expected=%0d", req, route_mode, exp);
    end
  endtask

  // R1: reset loads init value; 3 becomes 0
  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    init_mode = m;
    @(negedge clk);
    model = (m == 2'd3) ? 2'd0 : m;
    check("R1", model);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", model);
  endtask

  // drives one write at a negedge; result checked one edge later (R11)
  task automatic wr(string req, logic [4:0] slot, logic [7:0] ofs,
                    logic [7:0] v, logic alt, logic en);
    cfg_wr_en  = en;
    cfg_addr   = {slot, 3'($urandom % 8), ofs};
    cfg_wdata  = v;
    alt_bridge = alt;
    if (en && ofs == 8'h3C && !alt && model == 2'd0)
      model = expect_verdict(slot, v);
    @(negedge clk);
    cfg_wr_en  = 1'b0;
    alt_bridge = 1'b0;
    check(req, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11: watchdog expired, actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model = 2'd0;
    // R1 reset values
    do_reset(2'd1);
    do_reset(2'd2);
    do_reset(2'd3);
    do_reset(2'd0);
    // R2: 27 on slot 0 -> legacy
    wr("R2", 5'd0, 8'h3C, 8'd27, 1'b0, 1'b1);
    // R9: later write does nothing
    wr("R9", 5'd1, 8'h3C, 8'd55, 1'b0, 1'b1);
    // R3 + R10: 27 on slot 2 and 6 stays undecided, then probe
    do_reset(2'd0);
    wr("R3", 5'd2, 8'h3C, 8'd27, 1'b0, 1'b1);
    wr("R10", 5'd6, 8'h3C, 8'd27, 1'b0, 1'b1);
    wr("R3", 5'd2, 8'h3C, 8'd200, 1'b0, 1'b1);
    // R4: 30 on slot 3
    do_reset(2'd0);
    wr("R4", 5'd3, 8'h3C, 8'd30, 1'b0, 1'b1);
    // R5: 92 on slot 5 (mod 4 = 1)
    do_reset(2'd0);
    wr("R5", 5'd5, 8'h3C, 8'd92, 1'b0, 1'b1);
    // R6: 91 on slot 1 is not its signature
    do_reset(2'd0);
    wr("R6", 5'd1, 8'h3C, 8'd91, 1'b0, 1'b1);
    wr("R9", 5'd0, 8'h3C, 8'd27, 1'b0, 1'b1);
    // R7: wrong offset and no strobe ignored, R8 alternate variant ignored
    do_reset(2'd0);
    wr("R7", 5'd0, 8'h3D, 8'd99, 1'b0, 1'b1);
    wr("R7", 5'd0, 8'h3C, 8'd99, 1'b0, 1'b0);
    wr("R8", 5'd0, 8'h3C, 8'd99, 1'b1, 1'b1);
    wr("R11", 5'd0, 8'h3C, 8'd99, 1'b0, 1'b1);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      do_reset(($urandom % 3 == 0) ? 2'($urandom) : 2'd0);
      for (int k = 0; k < 4; k++) begin
        logic [4:0] sl;
        logic [7:0] ofs, v;
        sl  = 5'($urandom);
        ofs = ($urandom % 4 != 0) ? 8'h3C : 8'($urandom);
        case ($urandom % 4)
          0: v = 8'd27;
          1: v = 8'(27 + sl % 4);
          2: v = 8'(91 + sl % 4);
          default: v = 8'($urandom);
        endcase
        wr("R6", sl, ofs, v, ($urandom % 8 == 0), ($urandom % 8 != 0));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule